// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

A supervisory counter for a small microcontroller. A 12-bit prescaler divides a source tick and steps an 8-bit down counter. The source tick is either every cycle of the bus clock or each rising edge of a slow oscillator input. The oscillator input passes through a two-flop synchroniser into the bus-clock domain. In watchdog mode, a counter underflow or a broken key sequence produces a one-cycle reset pulse. When watchdog mode is off, an underflow sets a timeout flag that drives the interrupt output, and the counter keeps cycling as an interval timer.

Software keeps the counter alive by writing two key bytes in order. Writes to the control register go into a shadow copy. The shadow copy becomes active only when the next key sequence completes, so a stray write cannot quietly reconfigure or disable the block. The watchdog-mode bit is sticky: only the power-on reset clears it. The synchronous warm reset restores every other setting.

Top module: `wdog_keyed`

## Requirements
- R1: After power-on reset the control register reads 0x00, the load register 0xFF, the counter 0xFF, and `wdt_rst` and `irq` are low.
- R2: Register map. Address 0 is control: [7:5] divider select, [4] reads 0, [3] watchdog mode, [2] run, [1] timeout flag, [0] source select (1 = oscillator). Address 1 is the load register. Address 2 is key one and reads back the counter. Address 3 is key two and reads back 0.
- R3: The counter steps down once every 2^(SEL+5) source ticks, where SEL is the 3-bit divider select. The prescaler is 12 bits wide.
- R4: When a step finds the counter at 0, the counter reloads from the load register. From the edge that completes a key sequence, the underflow lands exactly (load+1)·2^(SEL+5) bus-clock edges later when the bus clock is the source.
- R5: The counter runs only with the run bit or watchdog mode set. In interval mode an underflow sets the timeout flag and `irq` follows it. Writing 0 to bit 1 of control clears the flag at once. Writing 1 leaves it unchanged.
- R6: In watchdog mode an underflow produces a `wdt_rst` pulse exactly one cycle wide, reloads the counter and clears the prescaler.
- R7: A valid feed is 0xA5 written to address 2 followed, as the next write, by 0x5A written to address 3. It reloads the counter from the load register and clears the prescaler, so regular feeding prevents any reset.
- R8: A bad sequence is any of the following: a wrong key-one value, a key-two write with no key one before it, or any write after key one other than 0x5A to address 3. A bad sequence is discarded. In watchdog mode it also produces a `wdt_rst` pulse. In interval mode it produces none.
- R9: A control write goes to the shadow register and takes effect only when the next feed completes. If the next write after a control write is not key one, the sequence is bad (R8) and that write is dropped.
- R10: Only power-on reset clears watchdog mode. A shadow value with bit 3 at 0 does not clear it. `sys_rst_n` clears everything else.
- R11: With the oscillator source selected, each rising edge of `osc_clk` gives one source tick, which the counter sees three bus-clock edges later.
- R12: `pwr_down` stops counting while the bus-clock source is selected. It has no effect on the oscillator source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_n | input | 1 | Synchronous warm reset, active low; keeps watchdog mode |
| pwr_down | input | 1 | Powered-down indication |
| osc_clk | input | 1 | Slow oscillator, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| wdt_rst | output | 1 | One-cycle reset pulse |
| irq | output | 1 | Timeout flag as interrupt |

## Verification
A write is sampled on a rising edge. Its consequences (reset pulse, flag change, reload, shadow transfer) are visible one edge later, and `rd_data` follows `addr` with no delay. An underflow with the bus-clock source falls (load+1)·2^(SEL+5) edges after the edge that accepts key two. An oscillator edge reaches the prescaler three edges after it is sampled. The bench drives inputs just after the falling edge. It steps a behavioural model on each rising edge and compares outputs and read data on each falling edge. Its timing checks count rising edges from the accepting edge, so every sample lands half a cycle after the edge that should produce the result.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int PSC_W    = 12,
  parameter int CNT_W    = 8,
  parameter int PRE_BASE = 5,
  parameter logic [7:0] KEY1 = 8'hA5,
  parameter logic [7:0] KEY2 = 8'h5A
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst_n,
  input  logic       pwr_down,
  input  logic       osc_clk,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rd_data,
  output logic       wdt_rst,
  output logic       irq
);
  localparam int PRE_W = 3;

  logic [PRE_W-1:0] pre_q, sh_pre;
  logic             sel_q, run_q, en_q, tof_q;
  logic             sh_sel, sh_run, sh_en;
  logic             pend_q, armed_q, rst_q;
  logic [CNT_W-1:0] load_q, cnt_q;
  logic [PSC_W-1:0] psc_q, psc_mask;
  logic [2:0]       osc_s;

  wire wr_ctl  = wr_en && addr == 2'd0;
  wire wr_load = wr_en && addr == 2'd1;
  wire wr_k1   = wr_en && addr == 2'd2;
  wire wr_k2   = wr_en && addr == 2'd3;

  wire k1_good  = wr_k1 && wdata == KEY1 && !armed_q;
  wire feed_ok  = wr_k2 && wdata == KEY2 && armed_q;
  wire feed_bad = wr_en && !k1_good && !feed_ok &&
                  (armed_q || wr_k1 || wr_k2 || pend_q);
  wire ctl_acc  = wr_ctl && !feed_bad;
  wire load_acc = wr_load && !feed_bad;

  always_comb psc_mask = {PSC_W{1'b1}} >> (PSC_W - PRE_BASE - int'(pre_q));

  wire src_tick = sel_q ? (osc_s[1] & ~osc_s[2]) : ~pwr_down;
  wire step     = src_tick && (en_q || run_q);
  wire dec      = step && ((psc_q & psc_mask) == psc_mask);
  wire uflow    = dec && cnt_q == '0 && !feed_ok;
  wire fire     = en_q && (uflow || feed_bad);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pre_q <= '0; sel_q <= 1'b0; run_q <= 1'b0; en_q <= 1'b0; tof_q <= 1'b0;
      sh_pre <= '0; sh_sel <= 1'b0; sh_run <= 1'b0; sh_en <= 1'b0;
      pend_q <= 1'b0; armed_q <= 1'b0; rst_q <= 1'b0;
      load_q <= '1; cnt_q <= '1; psc_q <= '0; osc_s <= '0;
    end else if (!sys_rst_n) begin
      pre_q <= '0; sel_q <= 1'b0; run_q <= 1'b0; tof_q <= 1'b0;
      sh_pre <= '0; sh_sel <= 1'b0; sh_run <= 1'b0; sh_en <= 1'b0;
      pend_q <= 1'b0; armed_q <= 1'b0; rst_q <= 1'b0;
      load_q <= '1; cnt_q <= '1; psc_q <= '0; osc_s <= '0;
    end else begin
      osc_s <= {osc_s[1:0], osc_clk};
      rst_q <= fire;

      if (feed_ok || fire) begin
        cnt_q <= load_q;
        psc_q <= '0;
      end else begin
        if (step) psc_q <= psc_q + 1'b1;
        if (dec)  cnt_q <= (cnt_q == '0) ? load_q : cnt_q - 1'b1;
      end

      if (load_acc) load_q <= wdata[CNT_W-1:0];

      if (uflow && !en_q)              tof_q <= 1'b1;
      else if (ctl_acc && !wdata[1])   tof_q <= 1'b0;

      if (feed_ok && pend_q) begin
        pre_q <= sh_pre;
        sel_q <= sh_sel;
        run_q <= sh_run;
        en_q  <= en_q | sh_en;
      end

      if (ctl_acc) begin
        sh_pre <= wdata[7:5];
        sh_en  <= wdata[3];
        sh_run <= wdata[2];
        sh_sel <= wdata[0];
        pend_q <= 1'b1;
      end else if (feed_ok || feed_bad) begin
        pend_q <= 1'b0;
      end

      if (wr_en) armed_q <= k1_good;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rd_data = {pre_q, 1'b0, en_q, run_q, tof_q, sel_q};
      2'd1:    rd_data = 8'(load_q);
      2'd2:    rd_data = 8'(cnt_q);
      default: rd_data = 8'h00;
    endcase
  end

  assign wdt_rst = rst_q;
  assign irq     = tof_q;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int PSC_W = 12,
  parameter int CNT_W = 8,
  parameter logic [7:0] KEY2 = 8'h5A
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [7:0]       wdata,
  input logic             wdt_rst,
  input logic             en_q,
  input logic             tof_q,
  input logic             armed_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] load_q,
  input logic [PSC_W-1:0] psc_q
);
  // R6
  rst_only_wd_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    wdt_rst |-> en_q);

  // R6
  rst_reload_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    wdt_rst |-> (cnt_q == $past(load_q) && psc_q == '0));

  // R10
  en_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    !$fell(en_q));

  // R5
  tof_interval_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    $rose(tof_q) |-> !en_q);

  // R7
  feed_reload_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (wr_en && addr == 2'd3 && wdata == KEY2 && armed_q) |=>
      (cnt_q == $past(load_q) && psc_q == '0));

  // R3
  psc_step_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (psc_q != $past(psc_q)) |-> (psc_q == '0 || psc_q == $past(psc_q) + 1'b1));
endmodule

bind wdog_keyed wdog_keyed_chk #(.PSC_W(PSC_W), .CNT_W(CNT_W), .KEY2(KEY2)) u_chk (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .wdt_rst(wdt_rst), .en_q(en_q), .tof_q(tof_q), .armed_q(armed_q),
  .cnt_q(cnt_q), .load_q(load_q), .psc_q(psc_q)
);

// File: tb/wdog_keyed_test.sv
`timescale 1ns/1ps
module wdog_keyed_test;
  logic clk = 1'b0, por_n = 1'b0, sys_rst_n = 1'b1, pwr_down = 1'b0, osc_clk = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rd_data;
  logic wdt_rst, irq;

  wdog_keyed uut (.clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .pwr_down(pwr_down),
    .osc_clk(osc_clk), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data),
    .wdt_rst(wdt_rst), .irq(irq));

  always #2 clk = ~clk;

  int tests = 0, fails = 0, rst_seen = 0;
  string cur_req = "R1";
  bit started = 0, osc_on = 0;

  int m_pre, m_sel, m_run, m_en, m_tof, m_load, m_cnt, m_psc;
  int s_pre, s_sel, s_run, s_en, m_pend, m_arm, m_rst;
  bit oq[$];

  task automatic m_reset(input bit keep_en);
    m_pre = 0; m_sel = 0; m_run = 0; m_tof = 0; m_load = 255; m_cnt = 255; m_psc = 0;
    s_pre = 0; s_sel = 0; s_run = 0; s_en = 0; m_pend = 0; m_arm = 0; m_rst = 0;
    oq = '{0, 0, 0};
    if (!keep_en) m_en = 0;
  endtask

  initial m_reset(0);

  always @(posedge clk) begin
    bit k1g, ok, bad, rise, step, dec, uf, fire;
    int div;
    started = 1;
    if (!por_n) m_reset(0);
    else if (!sys_rst_n) m_reset(1);
    else begin
      k1g = wr_en && addr == 2 && wdata == 8'hA5 && !m_arm;
      ok  = wr_en && addr == 3 && wdata == 8'h5A && m_arm;
      bad = 0;
      if (wr_en && !k1g && !ok) begin
        if (m_arm) bad = 1;
        else if (addr >= 2) bad = 1;
        else if (m_pend != 0) bad = 1;
      end
      rise = oq[1] && !oq[2];
      step = ((m_sel != 0) ? rise : !pwr_down) && (m_en != 0 || m_run != 0);
      div  = 32 << m_pre;
      dec  = step && (m_psc % div == div - 1);
      uf   = dec && m_cnt == 0 && !ok;
      fire = (m_en != 0) && (uf || bad);
      m_rst = fire;
      if (uf && m_en == 0) m_tof = 1;
      else if (wr_en && addr == 0 && !bad && !wdata[1]) m_tof = 0;
      if (ok || fire) begin
        m_cnt = m_load; m_psc = 0;
      end else begin
        if (step) m_psc = (m_psc + 1) % 4096;
        if (dec) m_cnt = (m_cnt == 0) ? m_load : m_cnt - 1;
      end
      if (wr_en && addr == 1 && !bad) m_load = wdata;
      if (ok && m_pend != 0) begin
        m_pre = s_pre; m_sel = s_sel; m_run = s_run; m_en = m_en | s_en;
      end
      if (wr_en && addr == 0 && !bad) begin
        s_pre = wdata[7:5]; s_en = wdata[3]; s_run = wdata[2]; s_sel = wdata[0]; m_pend = 1;
      end else if (ok || bad) m_pend = 0;
      if (wr_en) m_arm = k1g;
      oq.push_front(osc_clk);
      void'(oq.pop_back());
    end
  end

  always @(negedge clk) begin
    logic [7:0] exp_rd;
    if (started) begin
      case (addr)
        2'd0: exp_rd = {m_pre[2:0], 1'b0, m_en[0], m_run[0], m_tof[0], m_sel[0]};
        2'd1: exp_rd = m_load[7:0];
        2'd2: exp_rd = m_cnt[7:0];
        default: exp_rd = 8'h00;
      endcase
      tests++;
      if (wdt_rst !== m_rst[0] || irq !== m_tof[0] || rd_data !== exp_rd) begin
        fails++;
        $display("FAIL %s cycle model: rst=%0b irq=%0b rd=%02h expected rst=%0b irq=%0b rd=%02h",
                 cur_req, wdt_rst, irq, rd_data, m_rst[0], m_tof[0], exp_rd);
      end
      if (wdt_rst === 1'b1) rst_seen++;
    end
  end

  always @(negedge clk) begin
    int ph;
    #1;
    if (osc_on) begin
      ph++;
      if (ph >= 5) begin osc_clk = ~osc_clk; ph = 0; end
    end else begin
      ph = 0; osc_clk = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); #1;
    addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic feed();
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
  endtask

  task automatic feed_measure(input bit use_rst, output int n);
    wr(2'd2, 8'hA5);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = 2'd3; wdata = 8'h5A;
    @(posedge clk); #0.5;
    wr_en = 1'b0; addr = 2'd2;
    n = 0;
    while (n < 20000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if ((use_rst ? wdt_rst : irq) === 1'b1) break;
    end
  endtask

  function automatic logic [7:0] cv(input int p, input bit en, input bit run,
                                    input bit tof, input bit sel);
    return {p[2:0], 1'b0, en, run, tof, sel};
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  initial begin
    int v, w, n, snap;
    repeat (3) @(negedge clk);
    #1 por_n = 1'b1;

    cur_req = "R1";
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 load", v, 8'hFF);
    rd(2'd2, v); chk("R1 cnt", v, 8'hFF);
    chk("R1 rst", wdt_rst, 0);
    chk("R1 irq", irq, 0);

    cur_req = "R2";
    wr(2'd1, 8'h37);
    rd(2'd1, v); chk("R2 load readback", v, 8'h37);
    rd(2'd3, v); chk("R2 addr3 reads 0", v, 0);

    cur_req = "R9";
    wr(2'd0, cv(0, 0, 1, 0, 0));
    rd(2'd0, v); chk("R9 shadow not active", v, 8'h00);
    feed();
    rd(2'd0, v); chk("R9 applied on feed", v, 8'h04);

    cur_req = "R4";
    for (int p = 0; p < 8; p++) begin
      wr(2'd1, 8'd2);
      wr(2'd0, cv(p, 0, 1, 0, 0));
      feed_measure(1'b0, n);
      chk($sformatf("R4 R3 timeout SEL=%0d", p), n, 3 * (32 << p));
      chk("R4 reload after underflow", rd_data, 2);
    end

    cur_req = "R5";
    wr(2'd0, cv(7, 0, 1, 1, 0));
    chk("R5 writing 1 keeps flag", irq, 1);
    feed();
    chk("R5 flag still set", irq, 1);
    wr(2'd0, cv(7, 0, 1, 0, 0));
    chk("R5 writing 0 clears flag", irq, 0);
    feed();
    wr(2'd0, cv(7, 0, 0, 0, 0));
    feed();
    rd(2'd2, v);
    repeat (200) @(negedge clk);
    rd(2'd2, w); chk("R5 stopped without run", w, v);

    cur_req = "R8";
    snap = rst_seen;
    wr(2'd3, 8'h5A);
    wr(2'd2, 8'hA5); wr(2'd2, 8'hA5);
    repeat (3) @(negedge clk);
    chk("R8 no reset in interval mode", rst_seen, snap);

    cur_req = "R12";
    wr(2'd1, 8'hFF);
    wr(2'd0, cv(0, 0, 1, 0, 0));
    feed();
    #1 pwr_down = 1'b1;
    rd(2'd2, v);
    repeat (300) @(negedge clk);
    rd(2'd2, w); chk("R12 powered down holds", w, v);
    #1 pwr_down = 1'b0;
    repeat (100) @(negedge clk);
    rd(2'd2, w); chk("R12 resumes", (w != v), 1);

    cur_req = "R11";
    wr(2'd0, cv(0, 0, 1, 0, 1));
    feed();
    #1 pwr_down = 1'b1; osc_on = 1'b1;
    repeat (960) @(negedge clk);
    rd(2'd2, v);
    chk("R11 oscillator steps", (255 - v >= 2 && 255 - v <= 3), 1);
    #1 osc_on = 1'b0; pwr_down = 1'b0;

    cur_req = "R6";
    wr(2'd1, 8'd1);
    wr(2'd0, cv(0, 1, 0, 0, 0));
    feed_measure(1'b1, n);
    chk("R6 reset timing", n, 64);
    chk("R6 reload at pulse", rd_data, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", wdt_rst, 0);

    cur_req = "R7";
    snap = rst_seen;
    for (int i = 0; i < 6; i++) begin
      feed();
      repeat (30) @(negedge clk);
    end
    chk("R7 feeding prevents reset", rst_seen, snap);
    wr(2'd1, 8'hFF);
    wr(2'd0, cv(7, 1, 0, 0, 0));
    feed();

    cur_req = "R8";
    snap = rst_seen;
    wr(2'd2, 8'h11); @(negedge clk);
    chk("R8 wrong key one", rst_seen, snap + 1);
    wr(2'd3, 8'h5A); @(negedge clk);
    chk("R8 key two alone", rst_seen, snap + 2);
    wr(2'd2, 8'hA5); wr(2'd2, 8'hA5); @(negedge clk);
    chk("R8 key one twice", rst_seen, snap + 3);
    wr(2'd2, 8'hA5); wr(2'd1, 8'h10); @(negedge clk);
    chk("R8 other write after key one", rst_seen, snap + 4);

    cur_req = "R9";
    wr(2'd0, cv(0, 1, 0, 0, 0)); wr(2'd1, 8'h20); @(negedge clk);
    chk("R9 unconfirmed control resets", rst_seen, snap + 5);
    rd(2'd0, v); chk("R9 shadow discarded", v, 8'hE8);
    rd(2'd1, v); chk("R9 load write dropped", v, 8'hFF);

    cur_req = "R10";
    wr(2'd0, cv(7, 0, 0, 0, 0));
    feed();
    rd(2'd0, v); chk("R10 mode not cleared by write", v, 8'hE8);
    @(negedge clk); #1 sys_rst_n = 1'b0;
    @(negedge clk); #1 sys_rst_n = 1'b1;
    rd(2'd0, v); chk("R10 warm reset keeps mode", v, 8'h08);
    rd(2'd2, v); chk("R10 warm reset counter", v, 8'hFF);
    @(negedge clk); #1 por_n = 1'b0;
    @(negedge clk); #1 por_n = 1'b1;
    rd(2'd0, v); chk("R10 power-on clears mode", v, 8'h00);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule